// File: doc/BRIEF.md
# Dual-Limit Window Comparator Interrupt

This unit watches a stream of signed reduced-resolution samples and raises an interrupt when a sample passes either of two programmable thresholds. Each threshold is held as a limit word: a two's-complement value and a direction flag. The direction flag sets whether a sample above the threshold or a sample below it counts as a trip.

Two limits that point outward, one upper and one lower, report a signal that leaves a window. Two limits that point inward report a signal that sits inside the window. Each limit has its own sticky trip bit. The interrupt is the OR of the two trip bits. The host clears a trip bit by writing a one to its position in the clear mask.

Top module: `window_limit_irq`

## Requirements
- R1: After reset, `trip` is 2'b00 and `irq` is low. Both limit words reset to value 0 with direction "below", so after reset a negative sample trips both limits.
- R2: When the direction bit of a limit is 1, a valid sample strictly greater than that limit's value sets that limit's trip bit at the next clock edge.
- R3: When the direction bit of a limit is 0, a valid sample strictly less than that limit's value sets that limit's trip bit at the next clock edge.
- R4: A sample equal to a limit's value never trips that limit, whatever the direction.
- R5: Samples and limit values are (MAG_W+1)-bit two's-complement numbers, and they are compared as signed numbers.
- R6: A sample is evaluated only in a cycle where `smp_vld` is high. In any other cycle the trip bits cannot become set.
- R7: A trip bit stays set until `clr_we` is high with a 1 in that bit position of `clr_mask`. A 0 in a mask position leaves that bit unchanged, so each bit clears independently.
- R8: If a clear and a new trip of the same limit happen in the same cycle, the trip bit ends up set.
- R9: A single sample can set both trip bits.
- R10: `irq` is high exactly when at least one trip bit is set.
- R11: A limit write (`lim_we`) stores `lim_wdata` into limit 0 when `lim_sel` is 0 and into limit 1 when `lim_sel` is 1. Bit MAG_W+1 of the word is the direction bit and bits MAG_W..0 are the value. A sample presented in the same cycle as the write is compared against the old limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_val | input | MAG_W+1 | Signed sample value |
| lim_we | input | 1 | Limit word write enable |
| lim_sel | input | 1 | Selects which limit is written |
| lim_wdata | input | MAG_W+2 | Limit word: direction bit, then signed value |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 2 | Write-one-to-clear mask for the trip bits |
| irq | output | 1 | Interrupt, OR of the trip bits |
| trip | output | 2 | Sticky per-limit trip status |

## Verification
The limits are driven by samples just past them, exactly on them and just short of them, in both directions. This separates a strict comparison from an inclusive one. Limit pairs that mix negative and positive values show that the comparison is signed and not unsigned. Outward-facing and inward-facing pairs exercise single-bit trips and double trips. The clear tests combine partial masks, an all-zero mask and a clear that lands in the same cycle as a trip. The write test places a sample in the same cycle as a limit write, which shows which limit value the sample sees.

// File: rtl/window_limit_irq.sv
module window_limit_irq #(
  parameter int MAG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_vld,
  input  logic [MAG_W:0]     smp_val,
  input  logic               lim_we,
  input  logic               lim_sel,
  input  logic [MAG_W+1:0]   lim_wdata,
  input  logic               clr_we,
  input  logic [1:0]         clr_mask,
  output logic               irq,
  output logic [1:0]         trip
);
  localparam int VW = MAG_W + 1;
  localparam int LW = VW + 1;

  logic [LW-1:0] lim_q [2];
  logic [1:0]    hit;
  logic [1:0]    trip_q;

  for (genvar i = 0; i < 2; i++) begin : g_lim
    logic signed [VW-1:0] lv;
    logic                 up;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          lim_q[i] <= '0;
      else if (lim_we && lim_sel == 1'(i)) lim_q[i] <= lim_wdata;
    end

    assign lv     = lim_q[i][VW-1:0];
    assign up     = lim_q[i][VW];
    assign hit[i] = smp_vld && (up ? ($signed(smp_val) > lv) : ($signed(smp_val) < lv));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= '0;
    else        trip_q <= (trip_q & ~(clr_we ? clr_mask : 2'b00)) | hit;
  end

  assign trip = trip_q;
  assign irq  = |trip_q;
endmodule

// File: rtl/window_limit_irq_chk.sv
module window_limit_irq_chk #(
  parameter int MAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_vld,
  input logic [MAG_W:0]   smp_val,
  input logic             clr_we,
  input logic [1:0]       clr_mask,
  input logic             irq,
  input logic [1:0]       trip,
  input logic [MAG_W+1:0] lim [2]
);
  logic signed [MAG_W:0] s, l0, l1;
  assign s  = smp_val;
  assign l0 = lim[0][MAG_W:0];
  assign l1 = lim[1][MAG_W:0];

  p_gt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && lim[0][MAG_W+1] && s > l0) |=> trip[0]);

  p_lt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !lim[1][MAG_W+1] && s < l1) |=> trip[1]);

  p_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip[0] && s == l0) |=> !trip[0]);

  p_no_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ($countones(trip) <= $countones($past(trip))));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trip[1] && !(clr_we && clr_mask[1])) |=> trip[1]);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_mask[0] && !smp_vld) |=> !trip[0]);

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(smp_vld));
endmodule

bind window_limit_irq window_limit_irq_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_val(smp_val),
  .clr_we(clr_we), .clr_mask(clr_mask), .irq(irq), .trip(trip), .lim(lim_q)
);

// File: tb/tb_window_limit_irq.sv
module tb_window_limit_irq;
  localparam int MAG_W = 8;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             smp_vld = 0;
  logic [MAG_W:0]   smp_val = '0;
  logic             lim_we = 0;
  logic             lim_sel = 0;
  logic [MAG_W+1:0] lim_wdata = '0;
  logic             clr_we = 0;
  logic [1:0]       clr_mask = '0;
  logic             irq;
  logic [1:0]       trip;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  window_limit_irq #(.MAG_W(MAG_W)) dut (.*);

  task automatic chk(string req, logic [1:0] exp_trip);
    checks++;
    if (trip !== exp_trip || irq !== (|exp_trip)) begin
      errors++;
      $display("FAIL %s trip=%b irq=%b expected trip=%b irq=%b", req, trip, irq, exp_trip, |exp_trip);
    end
  endtask

  task automatic wr_lim(logic sel, logic up, int val);
    @(negedge clk);
    lim_we = 1; lim_sel = sel; lim_wdata = {up, 9'(val)};
    @(negedge clk);
    lim_we = 0;
  endtask

  task automatic smp(int val);
    @(negedge clk);
    smp_vld = 1; smp_val = 9'(val);
    @(negedge clk);
    smp_vld = 0;
  endtask

  task automatic clr(logic [1:0] m);
    @(negedge clk);
    clr_we = 1; clr_mask = m;
    @(negedge clk);
    clr_we = 0;
  endtask

  task automatic quiet();
    wr_lim(0, 0, -256);
    wr_lim(1, 1, 255);
    clr(2'b11);
  endtask

  task automatic t_reset();
    chk("R1", 2'b00);
    smp(-1);
    chk("R1", 2'b11);
    quiet();
    chk("R1", 2'b00);
  endtask

  task automatic t_gt();
    quiet();
    wr_lim(0, 1, 50);
    smp(50);  chk("R4", 2'b00);
    smp(49);  chk("R2", 2'b00);
    smp(51);  chk("R2", 2'b01);
  endtask

  task automatic t_lt();
    quiet();
    wr_lim(1, 0, -20);
    smp(-20); chk("R4", 2'b00);
    smp(-19); chk("R3", 2'b00);
    smp(-21); chk("R3", 2'b10);
  endtask

  task automatic t_signed();
    quiet();
    wr_lim(0, 1, -5);
    smp(3);    chk("R5", 2'b01);
    quiet();
    wr_lim(1, 0, 4);
    smp(-100); chk("R5", 2'b10);
    quiet();
    wr_lim(0, 1, 10);
    smp(-3);   chk("R5", 2'b00);
  endtask

  task automatic t_vld();
    quiet();
    wr_lim(0, 1, 0);
    @(negedge clk); smp_val = 9'(100); smp_vld = 0;
    @(negedge clk); @(negedge clk);
    chk("R6", 2'b00);
  endtask

  task automatic t_sticky();
    quiet();
    wr_lim(0, 1, 0);
    wr_lim(1, 0, 0);
    smp(5);   chk("R7", 2'b01);
    smp(-5);  chk("R7", 2'b11);
    smp(0);   chk("R7", 2'b11);
    clr(2'b00); chk("R7", 2'b11);
    clr(2'b01); chk("R7", 2'b10);
    clr(2'b10); chk("R10", 2'b00);
  endtask

  task automatic t_setwins();
    quiet();
    wr_lim(0, 1, 0);
    smp(7); chk("R8", 2'b01);
    @(negedge clk);
    clr_we = 1; clr_mask = 2'b01; smp_vld = 1; smp_val = 9'(8);
    @(negedge clk);
    clr_we = 0; smp_vld = 0;
    chk("R8", 2'b01);
  endtask

  task automatic t_both();
    quiet();
    wr_lim(0, 1, -10);
    wr_lim(1, 0, 10);
    smp(0);   chk("R9", 2'b11);
    quiet();
    wr_lim(0, 1, 10);
    wr_lim(1, 1, 20);
    smp(30);  chk("R9", 2'b11);
  endtask

  task automatic t_write();
    quiet();
    wr_lim(1, 0, -50);
    @(negedge clk);
    lim_we = 1; lim_sel = 0; lim_wdata = {1'b1, 9'(0)};
    smp_vld = 1; smp_val = 9'(5);
    @(negedge clk);
    lim_we = 0; smp_vld = 0;
    chk("R11", 2'b00);
    smp(5); chk("R11", 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gt();
    t_lt();
    t_signed();
    t_vld();
    t_sticky();
    t_setwins();
    t_both();
    t_write();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule